// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node of a small message-passing multiprocessor. For every memory line it keeps one directory entry: a three-way state (uncached, shared, or held by a single owner) and a full sharer bit-vector with one bit per processor. Requests arrive one at a time from requestor nodes. Each carries a kind (read, read-exclusive, upgrade), the requesting processor and the line index. The controller looks up the entry and writes the new entry back when it accepts the request. It then sends only the messages that request needs: invalidations or an intervention to the processors whose bits are set, a memory fetch, and a reply to the requestor.

Outgoing messages use a valid/ready handshake and carry a kind, a one-hot destination mask and the line index. When several processors must be invalidated, one invalidation is sent per handshake, lowest processor number first. Notifications always go out before the reply to the requestor. A memory fetch is a request held high until the memory acknowledges it. A new request is taken only once the previous one has sent all of its messages.

The owner state stands for both a clean exclusive copy and a dirty one. The controller cannot tell these apart, so it never sends data for a line in that state. Instead, the owner is told to supply the data or give up its copy.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every entry is uncached with no sharers, `req_ready` is 1, and `msg_valid` and `mem_req` are 0.
- R2: A read (req_type 0), read-exclusive (1) or upgrade (2) to an uncached line performs one memory fetch. It then sends a data reply (msg_type 0) to the requestor, and the requestor becomes the sole owner.
- R3: A read to an owned line sends exactly one intervention (msg_type 2) to the owner and performs no fetch. The line becomes shared, with the old owner and the requestor as sharers.
- R4: A read-exclusive or upgrade to a line owned by another processor sends exactly one invalidation (msg_type 3) to that owner and no other message. The requestor becomes the sole owner.
- R5: A read to a shared line performs one memory fetch and sends a data reply to the requestor. The line stays shared, with the requestor added to the sharers.
- R6: A read-exclusive to a shared line sends one invalidation to each other sharer in ascending processor order, then fetches and sends a data reply. The requestor becomes the sole owner.
- R7: An upgrade to a shared line invalidates every other sharer in ascending order, then sends a data-less reply (msg_type 1) with no fetch. The requestor becomes the sole owner.
- R8: A message stays valid with unchanged kind and destination until it is accepted. Each message has exactly one destination bit set and carries the request's line index.
- R9: `req_ready` is 1 only when no message or fetch is outstanding. A request presented while the controller is busy is ignored.
- R10: `mem_req` stays high with `mem_line` equal to the request's line until `mem_ack` is seen. A data reply is sent only after that acknowledge.
- R11: A request of kind 3 is accepted and dropped: no message, no fetch and no change to the entry.
- R12: Entries of different lines are independent. A request to one line leaves every other line's entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_type | input | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 none |
| req_src | input | PW | Requesting processor number |
| req_line | input | LW | Line index |
| mem_req | output | 1 | Memory fetch request |
| mem_line | output | LW | Line being fetched |
| mem_ack | input | 1 | Fetch complete |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network accepts the message |
| msg_type | output | 2 | 0 data reply, 1 data-less reply, 2 intervention, 3 invalidation |
| msg_dest | output | NPROC | One-hot destination processor |
| msg_line | output | LW | Line the message concerns |

## Verification
The bench walks one line through every state change in turn. Each step proves the previous entry through the messages of the next: a wrong owner after a read-exclusive shows up as an intervention sent to the wrong processor. The three-sharer read-exclusive runs under network back-pressure while a second request is held on the inputs. A design that skipped or reordered invalidations, changed a stalled message, or accepted a request while busy would produce a different message log. Kind-3 requests, upgrades from an uncached line and neighbouring lines are checked by the messages the next real request produces. A design that touched the entry or mixed up line indices would send an intervention where a data reply is expected.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_READX = 2'd1,
    RQ_UPGR  = 2'd2,
    RQ_NONE  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    MS_DATA = 2'd0,
    MS_ACK  = 2'd1,
    MS_INTV = 2'd2,
    MS_INV  = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_NOTE  = 2'd1,
    F_FETCH = 2'd2,
    F_REPLY = 2'd3
  } fsm_e;

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store import coh_pkg::*; #(
  parameter int NPROC  = 4,
  parameter int NLINES = 8,
  parameter int LW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     rd_line,
  output dir_state_e        rd_state,
  output logic [NPROC-1:0]  rd_shr,
  input  logic              wr_en,
  input  logic [LW-1:0]     wr_line,
  input  dir_state_e        wr_state,
  input  logic [NPROC-1:0]  wr_shr
);

  dir_state_e       st_q  [NLINES];
  logic [NPROC-1:0] shr_q [NLINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= ST_UNC;
        shr_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_line]  <= wr_state;
      shr_q[wr_line] <= wr_shr;
    end
  end

  assign rd_state = st_q[rd_line];
  assign rd_shr   = shr_q[rd_line];

endmodule

// File: rtl/coh_policy.sv
module coh_policy import coh_pkg::*; #(
  parameter int NPROC = 4,
  parameter int PW    = 2
) (
  input  dir_state_e        cur_state,
  input  logic [NPROC-1:0]  cur_shr,
  input  req_kind_e         kind,
  input  logic [PW-1:0]     src,
  output dir_state_e        nxt_state,
  output logic [NPROC-1:0]  nxt_shr,
  output logic [NPROC-1:0]  note_mask,
  output logic              note_intv,
  output logic              need_fetch,
  output logic              need_reply,
  output logic              reply_data,
  output logic              do_update
);

  function automatic logic [NPROC-1:0] bit_of(input logic [PW-1:0] p);
    return NPROC'(1) << p;
  endfunction

  logic [NPROC-1:0] src_bit;
  logic [NPROC-1:0] others;

  assign src_bit = bit_of(src);
  assign others  = cur_shr & ~src_bit;

  always_comb begin
    nxt_state  = cur_state;
    nxt_shr    = cur_shr;
    note_mask  = '0;
    note_intv  = 1'b0;
    need_fetch = 1'b0;
    need_reply = 1'b0;
    reply_data = 1'b0;
    do_update  = 1'b0;
    if (kind != RQ_NONE) begin
      do_update = 1'b1;
      unique case (cur_state)
        ST_UNC: begin
          nxt_state  = ST_EXC;
          nxt_shr    = src_bit;
          need_fetch = 1'b1;
          need_reply = 1'b1;
          reply_data = 1'b1;
        end
        ST_SHR: begin
          if (kind == RQ_READ) begin
            nxt_state  = ST_SHR;
            nxt_shr    = cur_shr | src_bit;
            need_fetch = 1'b1;
            need_reply = 1'b1;
            reply_data = 1'b1;
          end else begin
            nxt_state  = ST_EXC;
            nxt_shr    = src_bit;
            note_mask  = others;
            need_reply = 1'b1;
            need_fetch = (kind == RQ_READX);
            reply_data = (kind == RQ_READX);
          end
        end
        default: begin
          note_mask = others;
          if (kind == RQ_READ) begin
            nxt_state = ST_SHR;
            nxt_shr   = cur_shr | src_bit;
            note_intv = 1'b1;
          end else begin
            nxt_state = ST_EXC;
            nxt_shr   = src_bit;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/coh_pick_low.sv
module coh_pick_low #(
  parameter int N = 4
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] pick
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign pick[i]   = vec[i] & ~seen[i];
    assign seen[i+1] = seen[i] | vec[i];
  end

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir import coh_pkg::*; #(
  parameter int NPROC  = 4,
  parameter int NLINES = 8,
  localparam int PW = (NPROC  > 1) ? $clog2(NPROC)  : 1,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [PW-1:0]     req_src,
  input  logic [LW-1:0]     req_line,
  output logic              mem_req,
  output logic [LW-1:0]     mem_line,
  input  logic              mem_ack,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_type,
  output logic [NPROC-1:0]  msg_dest,
  output logic [LW-1:0]     msg_line
);

  fsm_e             fsm_q, fsm_d;
  logic [PW-1:0]    src_q;
  logic [LW-1:0]    line_q;
  logic [NPROC-1:0] pend_q, pend_d;
  logic             intv_q, fetch_q, reply_q, data_q;

  dir_state_e       cur_state, nxt_state;
  logic [NPROC-1:0] cur_shr, nxt_shr, note_mask, pick_bit;
  logic             note_intv, need_fetch, need_reply, reply_data, do_update;

  // named internal events
  logic accept, note_fire, reply_fire, fetch_done;
  msg_kind_e mk;

  assign req_ready  = (fsm_q == F_IDLE);
  assign accept     = req_valid && req_ready;
  assign note_fire  = (fsm_q == F_NOTE)  && msg_ready;
  assign reply_fire = (fsm_q == F_REPLY) && msg_ready;
  assign fetch_done = (fsm_q == F_FETCH) && mem_ack;

  coh_dir_store #(.NPROC(NPROC), .NLINES(NLINES), .LW(LW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_line  (req_line),
    .rd_state (cur_state),
    .rd_shr   (cur_shr),
    .wr_en    (accept && do_update),
    .wr_line  (req_line),
    .wr_state (nxt_state),
    .wr_shr   (nxt_shr)
  );

  coh_policy #(.NPROC(NPROC), .PW(PW)) u_policy (
    .cur_state  (cur_state),
    .cur_shr    (cur_shr),
    .kind       (req_kind_e'(req_type)),
    .src        (req_src),
    .nxt_state  (nxt_state),
    .nxt_shr    (nxt_shr),
    .note_mask  (note_mask),
    .note_intv  (note_intv),
    .need_fetch (need_fetch),
    .need_reply (need_reply),
    .reply_data (reply_data),
    .do_update  (do_update)
  );

  coh_pick_low #(.N(NPROC)) u_pick (
    .vec  (pend_q),
    .pick (pick_bit)
  );

  always_comb begin
    fsm_d  = fsm_q;
    pend_d = pend_q;
    unique case (fsm_q)
      F_IDLE: begin
        if (accept) begin
          pend_d = note_mask;
          if (|note_mask)      fsm_d = F_NOTE;
          else if (need_fetch) fsm_d = F_FETCH;
          else if (need_reply) fsm_d = F_REPLY;
        end
      end
      F_NOTE: begin
        if (note_fire) begin
          pend_d = pend_q & ~pick_bit;
          if (pend_d == '0) begin
            if (fetch_q)      fsm_d = F_FETCH;
            else if (reply_q) fsm_d = F_REPLY;
            else              fsm_d = F_IDLE;
          end
        end
      end
      F_FETCH: if (fetch_done) fsm_d = F_REPLY;
      default: if (reply_fire) fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q   <= F_IDLE;
      pend_q  <= '0;
      src_q   <= '0;
      line_q  <= '0;
      intv_q  <= 1'b0;
      fetch_q <= 1'b0;
      reply_q <= 1'b0;
      data_q  <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      pend_q <= pend_d;
      if (accept) begin
        src_q   <= req_src;
        line_q  <= req_line;
        intv_q  <= note_intv;
        fetch_q <= need_fetch;
        reply_q <= need_reply;
        data_q  <= reply_data;
      end
    end
  end

  always_comb begin
    if (fsm_q == F_NOTE) mk = intv_q ? MS_INTV : MS_INV;
    else                 mk = data_q ? MS_DATA : MS_ACK;
  end

  assign msg_valid = (fsm_q == F_NOTE) || (fsm_q == F_REPLY);
  assign msg_type  = mk;
  assign msg_dest  = (fsm_q == F_NOTE) ? pick_bit : (NPROC'(1) << src_q);
  assign msg_line  = line_q;
  assign mem_req   = (fsm_q == F_FETCH);
  assign mem_line  = line_q;

endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk #(
  parameter int NPROC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [1:0]       msg_type,
  input logic [NPROC-1:0] msg_dest,
  input logic             note_fire
);

  logic fetched_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    fetched_q <= 1'b0;
    else if (req_valid && req_ready) fetched_q <= 1'b0;
    else if (mem_req && mem_ack)   fetched_q <= 1'b1;
  end

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type) && $stable(msg_dest))); // R8

  AST_DEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ($countones(msg_dest) == 1)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!msg_valid && !mem_req)); // R9

  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req); // R10

  AST_DATA_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 2'd0) |-> fetched_q); // R10

  AST_INV_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 2'd3 && $past(note_fire && msg_type == 2'd3))
      |-> (msg_dest > $past(msg_dest))); // R6

endmodule

bind coh_home_dir coh_home_dir_chk #(.NPROC(NPROC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_type  (msg_type),
  .msg_dest  (msg_dest),
  .note_fire (note_fire)
);

// File: tb/coh_home_dir_bench.sv
module coh_home_dir_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NL = 8;
  localparam int PW = 2;
  localparam int LW = 3;
  localparam int K_MEM = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_type = '0;
  logic [PW-1:0] req_src = '0;
  logic [LW-1:0] req_line = '0;
  logic          mem_req;
  logic [LW-1:0] mem_line;
  logic          mem_ack = 1'b0;
  logic          msg_valid;
  logic          msg_ready = 1'b0;
  logic [1:0]    msg_type;
  logic [NP-1:0] msg_dest;
  logic [LW-1:0] msg_line;

  coh_home_dir #(.NPROC(NP), .NLINES(NL)) u_coh_home_dir (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_line(req_line),
    .mem_req(mem_req), .mem_line(mem_line), .mem_ack(mem_ack),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_dest(msg_dest), .msg_line(msg_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  int got_k [16];
  int got_d [16];
  int got_l [16];
  int got_n;
  int exp_k [16];
  int exp_d [16];
  int exp_n;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic log_ev(input int k, input int d, input int l);
    if (got_n < 16) begin
      got_k[got_n] = k; got_d[got_n] = d; got_l[got_n] = l;
    end
    got_n++;
  endtask

  task automatic exp_clear();
    exp_n = 0;
  endtask

  task automatic exp_add(input int k, input int d);
    exp_k[exp_n] = k; exp_d[exp_n] = d; exp_n++;
  endtask

  // drive one request, serve memory and network, log every event
  task automatic run_req(input int kind, input int src, input int line,
                         input bit poke, input int stall, input string tag);
    int  sc = 0;
    int  mw = 0;
    bit  held = 0;
    int  pt = 0;
    int  pd = 0;
    bit  done = 0;
    got_n = 0;
    @(negedge clk);
    chk({tag, " R9 ready before request"}, int'(req_ready), 1);
    req_valid = 1'b1; req_type = 2'(kind); req_src = PW'(src); req_line = LW'(line);
    @(negedge clk);
    if (poke) begin
      req_type = 2'd1; req_src = 2'd3; req_line = LW'(line);
    end else begin
      req_valid = 1'b0;
    end
    for (int it = 0; it < 300 && !done; it++) begin
      mem_ack = 1'b0; msg_ready = 1'b0;
      if (req_ready) begin
        req_valid = 1'b0;
        done = 1;
      end else begin
        if (msg_valid) begin
          if (held) begin
            chk({tag, " R8 stalled kind"}, int'(msg_type), pt);
            chk({tag, " R8 stalled dest"}, int'(msg_dest), pd);
          end
          sc++;
          if (sc > stall) begin
            sc = 0; held = 0;
            log_ev(int'(msg_type), int'(msg_dest), int'(msg_line));
            msg_ready = 1'b1;
          end else begin
            held = 1; pt = int'(msg_type); pd = int'(msg_dest);
          end
        end else if (held) begin
          chk({tag, " R8 message withdrawn"}, 0, 1);
          held = 0;
        end
        if (mem_req) begin
          mw++;
          if (mw >= 3) begin
            log_ev(K_MEM, 0, int'(mem_line));
            mem_ack = 1'b1; mw = 0;
          end
        end else if (mw != 0) begin
          chk({tag, " R10 fetch dropped before ack"}, 0, 1);
          mw = 0;
        end
        @(negedge clk);
      end
    end
    if (!done) chk({tag, " R9 controller never returned idle"}, 0, 1);
  endtask

  task automatic compare(input string tag, input int line);
    chk({tag, " event count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < 16; i++) begin
      chk($sformatf("%s event %0d kind", tag, i), got_k[i], exp_k[i]);
      chk($sformatf("%s event %0d dest", tag, i), got_d[i], exp_d[i]);
      chk($sformatf("%s event %0d line R8/R10", tag, i), got_l[i], line);
    end
  endtask

  task automatic t_reset();
    chk("R1 req_ready after reset", int'(req_ready), 1);
    chk("R1 msg_valid after reset", int'(msg_valid), 0);
    chk("R1 mem_req after reset", int'(mem_req), 0);
    run_req(0, 2, 0, 0, 0, "R1");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 4);
    compare("R1 line 0 starts uncached", 0);
  endtask

  task automatic t_uncached();
    run_req(1, 0, 3, 0, 0, "R2a");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 1);
    compare("R2 readx from uncached", 3);
    run_req(0, 1, 3, 0, 0, "R2b");
    exp_clear(); exp_add(2, 1);
    compare("R2 owner recorded (R3 intervention)", 3);
    run_req(2, 3, 4, 0, 0, "R2c");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 8);
    compare("R2 upgrade from uncached", 4);
    run_req(1, 1, 4, 0, 0, "R4a");
    exp_clear(); exp_add(3, 8);
    compare("R4 readx on owned line", 4);
  endtask

  task automatic t_chain();
    run_req(0, 1, 2, 0, 0, "c1");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 2);
    compare("R2 read from uncached", 2);
    run_req(0, 2, 2, 0, 1, "c2");
    exp_clear(); exp_add(2, 2);
    compare("R3 read on owned line", 2);
    run_req(0, 3, 2, 0, 0, "c3");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 8);
    compare("R5 read on shared line", 2);
    run_req(1, 0, 2, 1, 2, "c4");
    exp_clear(); exp_add(3, 2); exp_add(3, 4); exp_add(3, 8);
    exp_add(K_MEM, 0); exp_add(0, 1);
    compare("R6 readx on shared, stalled and poked (R9)", 2);
    run_req(1, 2, 2, 0, 0, "c5");
    exp_clear(); exp_add(3, 1);
    compare("R4 readx moves owner", 2);
    run_req(0, 1, 2, 0, 0, "c6");
    exp_clear(); exp_add(2, 4);
    compare("R4 new owner gets intervention", 2);
    run_req(2, 1, 2, 0, 1, "c7");
    exp_clear(); exp_add(3, 4); exp_add(1, 2);
    compare("R7 upgrade on shared", 2);
    run_req(0, 3, 2, 0, 0, "c8");
    exp_clear(); exp_add(2, 2);
    compare("R7 upgrader is owner", 2);
  endtask

  task automatic t_ignore();
    run_req(3, 2, 5, 0, 0, "R11a");
    exp_clear();
    compare("R11 kind 3 sends nothing", 5);
    run_req(0, 1, 5, 0, 0, "R11b");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 2);
    compare("R11 uncached line untouched", 5);
    run_req(3, 0, 2, 0, 0, "R11c");
    exp_clear();
    compare("R11 kind 3 on shared line", 2);
    run_req(0, 0, 2, 0, 0, "R11d");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 1);
    compare("R11 shared line still shared", 2);
    run_req(2, 0, 2, 0, 0, "R11e");
    exp_clear(); exp_add(3, 2); exp_add(3, 8); exp_add(1, 1);
    compare("R11 sharers kept", 2);
  endtask

  task automatic t_lines();
    run_req(0, 0, 6, 0, 0, "R12a");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 1);
    compare("R12 line 6 fetch", 6);
    run_req(0, 1, 7, 0, 0, "R12b");
    exp_clear(); exp_add(K_MEM, 0); exp_add(0, 2);
    compare("R12 line 7 unaffected by line 6", 7);
    run_req(0, 2, 6, 0, 0, "R12c");
    exp_clear(); exp_add(2, 1);
    compare("R12 line 6 owner kept", 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_uncached();
    t_chain();
    t_ignore();
    t_lines();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule